// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter, four bits wide by default, with a parallel preset and a combinational terminal-count flag. It has two count-enable inputs. A parallel enable goes to every stage of a chain. A chain enable is also gated into the terminal-count output, so the flag of one stage can feed the chain enable of the next. Any number of stages that share one clock then behave as a single wider binary counter, and no stage needs a carry register.

The master reset is active low. A build-time parameter chooses how it acts. In the asynchronous variant it clears the count at once, whatever the clock is doing. In the synchronous variant it clears the count only at a rising clock edge. Apart from an asynchronous reset, every change of state happens on the rising clock edge, and loading the preset always wins over counting.

Top module: `casc_bin_counter`

## Requirements
- R1: Apart from an asynchronous reset, the count changes only at a rising edge of `clk`. Input changes between edges leave `count` as it was.
- R2: With `ASYNC_RESET`=1, a low `rst_n` forces `count` to 0 at once, without a clock edge. It holds 0 while `rst_n` stays low, whatever `load_n`, `par_en` and `chain_in` are.
- R3: With `ASYNC_RESET`=0, a low `rst_n` has no effect until the next rising edge, where it clears `count` to 0. This reset takes precedence over a load at that same edge.
- R4: When `load_n` is 0 at a rising edge and reset is inactive, `count` takes the value of `preset`, whatever the two enables are. Bit i of `preset` goes to bit i of `count`.
- R5: When `load_n` is 1 and both `par_en` and `chain_in` are 1 at a rising edge, `count` increases by one. From all ones it wraps to 0.
- R6: When `load_n` is 1 and either enable is 0 at a rising edge, `count` keeps its value.
- R7: `term_cnt` is 1 exactly when `chain_in` is 1 and `count` is all ones. It follows those two without a clock edge and does not depend on `par_en`.
- R8: N stages that share `clk`, `rst_n`, `load_n` and `par_en`, where stage 0 takes the external chain enable and stage k+1 takes the `term_cnt` of stage k, count as a single binary counter of N×WIDTH bits. Stage 0 holds the low bits. The last stage's `term_cnt` is 1 at the all-ones value when the external chain enable is 1.
- R9: After reset, `count` is 0 and `term_cnt` is 0, and every bit of both has a known value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Master reset, active low; asynchronous or synchronous according to `ASYNC_RESET` |
| load_n | input | 1 | Synchronous parallel load, active low |
| par_en | input | 1 | Parallel count enable, active high |
| chain_in | input | 1 | Chain count enable, active high; also gates `term_cnt` |
| preset | input | WIDTH | Value copied into the count on a load |
| count | output | WIDTH | Current count |
| term_cnt | output | 1 | Terminal count: `chain_in` high and count all ones |

## Verification
A load and an enabled count can fall on the same edge. The bench provokes this by driving `load_n` low with both enables high, both on directed edges and often in the random phase, and it expects the preset to win. A reset can also coincide with a load: the bench holds `rst_n` low while `load_n` is low and a preset is applied, and it expects zero on both reset variants. A three-stage chain runs beside the single counters and is compared with a 12-bit reference value, including at the stage boundaries 0x0EF to 0x0F0 and 0xFFF to 0x000.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  // Operation chosen for the next rising edge (reset handled separately)
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INCR = 2'd2
  } cbc_op_e;

  // Load wins over counting; counting needs both enables
  function automatic cbc_op_e select_op(logic load_n, logic en_par, logic en_chain);
    if (!load_n)                return OP_LOAD;
    else if (en_par && en_chain) return OP_INCR;
    return OP_HOLD;
  endfunction

endpackage

// File: rtl/cbc_op_decode.sv
module cbc_op_decode
  import cbc_pkg::*;
(
  input  logic    load_n,
  input  logic    par_en,
  input  logic    chain_in,
  output cbc_op_e op
);

  always_comb op = select_op(load_n, par_en, chain_in);

endmodule

// File: rtl/cbc_count_reg.sv
module cbc_count_reg
  import cbc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cbc_op_e          op,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  function automatic logic [WIDTH-1:0] step_value(cbc_op_e o, logic [WIDTH-1:0] cur,
                                                  logic [WIDTH-1:0] pre);
    case (o)
      OP_LOAD: return pre;
      OP_INCR: return cur + ONE;
      default: return cur;
    endcase
  endfunction

  logic [WIDTH-1:0] count_d;
  always_comb count_d = step_value(op, count, preset);

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= ZERO;
        else        count <= count_d;
      end

      AST_ASYNC_CLEAR: assert property (@(posedge clk)
        !rst_n |-> count == ZERO);  // R2
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) count <= ZERO;
        else        count <= count_d;
      end

      AST_SYNC_CLEAR: assert property (@(posedge clk)
        !rst_n |=> count == ZERO);  // R3
    end
  endgenerate

  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> count == $past(preset));  // R4
  AST_INCR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_INCR |=> count == $past(count) + ONE);  // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(count));  // R6

endmodule

// File: rtl/cbc_tc_detect.sv
module cbc_tc_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             chain_in,
  output logic             term_cnt
);

  function automatic logic is_max(logic [WIDTH-1:0] v);
    return &v;
  endfunction

  always_comb term_cnt = chain_in & is_max(count);

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import cbc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             par_en,
  input  logic             chain_in,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             term_cnt
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] ZERO     = '0;

  cbc_op_e op;

  cbc_op_decode u_decode (
    .load_n   (load_n),
    .par_en   (par_en),
    .chain_in (chain_in),
    .op       (op)
  );

  cbc_count_reg #(
    .WIDTH       (WIDTH),
    .ASYNC_RESET (ASYNC_RESET)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .preset (preset),
    .count  (count)
  );

  cbc_tc_detect #(
    .WIDTH (WIDTH)
  ) u_tc (
    .count    (count),
    .chain_in (chain_in),
    .term_cnt (term_cnt)
  );

  AST_TC_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_in |-> !term_cnt);  // R7
  AST_TC_IGNORES_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_en && chain_in && count == ALL_ONES) |-> term_cnt);  // R7
  AST_WRAP_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && par_en && load_n) |=> count == ZERO);  // R5

endmodule

// File: tb/sim_casc_bin_counter.sv
module sim_casc_bin_counter;
  localparam int W  = 4;
  localparam int N  = 3;
  localparam int CW = W * N;

  logic clk = 1'b0;
  always #5 clk = ~clk;  // 100 MHz

  logic rst_a_n = 1'b1, rst_s_n = 1'b1;
  logic load_n = 1'b1, pe = 1'b0, te = 1'b0;
  logic [W-1:0]  pre   = '0;
  logic [CW-1:0] pre_c = '0;
  logic [W-1:0]  q_a, q_s;
  logic          tc_a, tc_s;
  logic [CW-1:0] q_c;
  logic [N-1:0]  tc_c;
  logic [N:0]    link;

  int checks = 0, failures = 0;
  bit done = 0;
  int unsigned m_a = 0, m_s = 0, m_c = 0;

  casc_bin_counter #(.WIDTH(W), .ASYNC_RESET(1'b1)) u0 (
    .clk(clk), .rst_n(rst_a_n), .load_n(load_n), .par_en(pe), .chain_in(te),
    .preset(pre), .count(q_a), .term_cnt(tc_a));

  casc_bin_counter #(.WIDTH(W), .ASYNC_RESET(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .load_n(load_n), .par_en(pe), .chain_in(te),
    .preset(pre), .count(q_s), .term_cnt(tc_s));

  assign link[0] = te;
  for (genvar i = 0; i < N; i++) begin : g_chain
    casc_bin_counter #(.WIDTH(W), .ASYNC_RESET(1'b1)) u_stage (
      .clk(clk), .rst_n(rst_a_n), .load_n(load_n), .par_en(pe), .chain_in(link[i]),
      .preset(pre_c[i*W +: W]), .count(q_c[i*W +: W]), .term_cnt(tc_c[i]));
    assign link[i+1] = tc_c[i];
  end

  // Reference behaviour, written from the requirements
  function automatic int unsigned f_next(int unsigned cur, int unsigned ld_v, bit ld_n,
                                         bit a, bit b, int bits);
    if (!ld_n) return ld_v;
    if (a && b) return (cur + 1) % (1 << bits);
    return cur;
  endfunction

  function automatic bit f_tc(int unsigned cur, bit b, int bits);
    return b && (cur == (1 << bits) - 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " async count"}, 32'(q_a), m_a);
    chk({tag, " sync count"},  32'(q_s), m_s);
    chk({tag, " chain count"}, 32'(q_c), m_c);
    chk({tag, " async tc"},    32'(tc_a), 32'(f_tc(m_a, te, W)));
    chk({tag, " sync tc"},     32'(tc_s), 32'(f_tc(m_s, te, W)));
    chk({tag, " chain tc"},    32'(tc_c[N-1]), 32'(f_tc(m_c, te, CW)));
  endtask

  // Called just after a falling edge with inputs set; returns after the next falling edge
  task automatic step();
    m_a = !rst_a_n ? 0 : f_next(m_a, pre, load_n, pe, te, W);
    m_s = !rst_s_n ? 0 : f_next(m_s, pre, load_n, pe, te, W);
    m_c = !rst_a_n ? 0 : f_next(m_c, pre_c, load_n, pe, te, CW);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #2;
    rst_a_n = 1'b0; rst_s_n = 1'b0;
    @(negedge clk); step(); step();
    rst_a_n = 1'b1; rst_s_n = 1'b1; te = 1'b1;
    check_all("R9 reset state");

    // R4: load with both enables high, preset wins
    load_n = 1'b0; pe = 1'b1; te = 1'b1; pre = 4'd9; pre_c = 12'h0EE;
    step(); check_all("R4 load over count");

    // R1: input changes mid-cycle do nothing before the edge
    pre = 4'd3; pre_c = 12'h123; pe = 1'b0;
    #2 check_all("R1 no change before edge");
    step(); check_all("R4 load with enables low");

    // R5 / R8: count across the stage boundary 0x0EF -> 0x0F0
    pre_c = 12'h0EE; step(); load_n = 1'b1; pe = 1'b1;
    step(); check_all("R8 chain reaches 0EF");
    step(); check_all("R8 chain crosses boundary");

    // R7: terminal count and par_en independence
    load_n = 1'b0; pre = 4'hF; pre_c = 12'hFFF; step();
    load_n = 1'b1; pe = 1'b0; te = 1'b1;
    #1 check_all("R7 tc high with par_en low");
    step(); check_all("R6 hold with par_en low");
    te = 1'b0; pe = 1'b1;
    #1 check_all("R7 tc low with chain_in low");
    step(); check_all("R6 hold with chain_in low");
    te = 1'b1;
    step(); check_all("R5 wrap to zero");
    step(); check_all("R5 count after wrap");

    // R2: asynchronous reset mid-cycle, beats load
    load_n = 1'b0; pre = 4'd9; pre_c = 12'hABC; step();
    #1 rst_a_n = 1'b0;
    #1 m_a = 0; m_c = 0;
    check_all("R2 clear without edge");
    pre = 4'd6; step(); check_all("R2 reset beats load");
    rst_a_n = 1'b1; load_n = 1'b1; step(); check_all("R2 count after release");

    // R3: synchronous reset waits for the edge, beats load
    load_n = 1'b0; pre = 4'd10; step();
    rst_s_n = 1'b0; pre = 4'd5;
    #2 check_all("R3 no clear before edge");
    step(); check_all("R3 clear at edge over load");
    rst_s_n = 1'b1; load_n = 1'b1; step(); check_all("R3 count after release");

    // R8: chain runs through 0xFFD .. 0x001
    load_n = 1'b0; pre_c = 12'hFFD; pre = 4'hD; step();
    load_n = 1'b1; pe = 1'b1; te = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step(); check_all("R8 chain top wrap");
    end

    // Random phase: R4 R5 R6 R7 R8 together
    for (int k = 0; k < 400; k++) begin
      load_n = ($urandom % 8) != 0;
      pe     = ($urandom % 8) != 0;
      te     = ($urandom % 8) != 0;
      pre    = W'($urandom);
      pre_c  = (($urandom % 4) == 0) ? (12'hFF0 | 12'($urandom % 16)) : CW'($urandom);
      #1 check_all("R7 random tc before edge");
      step(); check_all("R5 R6 random after edge");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule